// File: doc/BRIEF.md
# Shared-Source Edge-Triggered Timer Interrupt Channel

This block gathers the three event flags of a timer (input capture, output compare, counter overflow) and turns them into one interrupt request for an external interrupt controller. Each flag has its own enable. The enabled flags are ORed onto one internal line, and that line reaches the channel only while a routing bit is set. The channel has an edge detector with a selectable polarity, a pending latch, a mask and a 3-bit priority value that is passed on to the arbiter.

The channel is edge-sensitive, so a source that fires while another enabled flag is still set produces no new request. Service software must bring every flag back to zero at the same time at least once. If it does not, the line never drops and the channel issues no more requests. A flag clears through a two-step read: first read the status register, then read the low data register that belongs to that source.

Top module: `tmr_irq_channel`

## Requirements
- R1: After reset, all flags, enables, the routing bit, the pending bit, the mask and the priority are zero. The edge select is rising and `irq_req` is low.
- R2: A one-cycle pulse on `evt_cap`, `evt_cmp` or `evt_ovf` sets bit 0, 1 or 2 of the status register (address 0), and the bit stays set. Enables have no effect on flag setting.
- R3: The control register is at address 1, with bits [2:0] as the source enables (cap, cmp, ovf) and bit 3 as the routing bit. With rising edge selected, an enabled flag with routing on that drives the line from 0 to 1 sets the pending bit one clock after the flag is set. `irq_req` then goes high while the mask is 1.
- R4: A set flag whose enable is 0, or any flag while the routing bit is 0, leaves the pending bit at 0.
- R5: A flag clears when the status register is read while the flag is set and the next access is a read of that source's low register: address 3 for cap, 4 for cmp, 5 for ovf. A low read that is not preceded by a status read leaves the flag set.
- R6: Any other register access between the status read and the low read cancels the clear.
- R7: While any enabled, routed flag stays set, a new event on another source does not set the pending bit. Once all such flags are clear, the next event sets it again.
- R8: The channel register is at address 2, with bit 0 as the edge select (1 = falling), bit 1 as the pending bit, bit 2 as the mask and bits [5:3] as the priority. Writing 0 to bit 1 clears the pending bit. Writing 1 to bit 1 leaves it unchanged.
- R9: With falling edge selected, the pending bit sets one clock after the line drops from 1 to 0. A rising line does not set it.
- R10: If an event and the clearing low read hit the same flag in the same cycle, the flag stays set.
- R11: `irq_prio` shows the priority field. `irq_req` stays low while the mask is 0, even if the pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_cap | input | 1 | Input capture event pulse |
| evt_cmp | input | 1 | Output compare event pulse |
| evt_ovf | input | 1 | Counter overflow event pulse |
| cap_lo | input | 8 | Capture low byte, read at address 3 |
| cmp_lo | input | 8 | Compare low byte, read at address 4 |
| cnt_lo | input | 8 | Counter low byte, read at address 5 |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| irq_req | output | 1 | Request to the interrupt controller |
| irq_prio | output | 3 | Priority level for the arbiter |

## Verification
The channel is exercised with a single source firing on a quiet line, which must raise a request. It is then hit with a second source firing while a first flag is still set, which must raise nothing. The same patterns are repeated with the routing bit off and with an enable off, to show that gating applies only to the line and not to flag setting. Clear sequences are run in three forms: correct order, a low read alone, and a pair broken by an unrelated access. A clear is also made to collide with an event in the same cycle. The falling-edge mode is driven by setting a flag and then clearing it, which separates the two polarities because the request may appear only on the clear.

// File: rtl/tmr_irq_pkg.sv
// Package: shared constants and register addresses for the timer interrupt channel.
// Assumes: source index 0 = capture, 1 = compare, 2 = overflow.
package tmr_irq_pkg;
    localparam int NSRC = 3;
    localparam int AW   = 3;
    localparam int DW   = 8;
    localparam int PW   = 3;

    typedef enum logic [AW-1:0] {
        A_STAT   = 3'd0,
        A_CTRL   = 3'd1,
        A_CHAN   = 3'd2,
        A_CAP_LO = 3'd3,
        A_CMP_LO = 3'd4,
        A_CNT_LO = 3'd5
    } reg_addr_e;

    localparam logic [AW-1:0] LO_BASE = A_CAP_LO;
endpackage

// File: rtl/tmr_irq_flags.sv
// Module: per-source event flags with the two-step (status read, then low read) clear.
// Assumes: low registers sit at consecutive addresses from LO_BASE in source order;
// any access other than the status read cancels the pending clear.
module tmr_irq_flags #(
    parameter int NSRC = 3,
    parameter int AW   = 3,
    parameter logic [AW-1:0] STAT_ADDR = '0,
    parameter logic [AW-1:0] LO_BASE   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            acc_en,
    input  logic            acc_wr,
    input  logic [AW-1:0]   acc_addr,
    output logic [NSRC-1:0] flags
);
    logic rd_stat;

    // Decode a status read.
    always_comb rd_stat = acc_en && !acc_wr && (acc_addr == STAT_ADDR);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic armed;
        logic low_rd;
        logic clr;

        // Decode the read of this source's low register and the resulting clear.
        always_comb begin
            low_rd = acc_en && !acc_wr && (acc_addr == AW'(LO_BASE + AW'(i)));
            clr    = low_rd && armed;
        end

        // Arm on a status read that saw the flag set; any other access disarms.
        always_ff @(posedge clk) begin
            if (!rst_n)       armed <= 1'b0;
            else if (rd_stat) armed <= flags[i];
            else if (acc_en)  armed <= 1'b0;
        end

        // Flag register: an event wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= evt[i] | (flags[i] & ~clr);
        end
    end
endmodule

// File: rtl/tmr_irq_edge.sv
// Module: edge detector and pending latch of the interrupt channel.
// Assumes: the line is sampled once per clock; a detected edge wins over a software clear.
module tmr_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic edge_fall,
    input  logic pend_clr,
    output logic pend
);
    logic line_q;
    logic trig;

    // Keep a one-cycle delayed copy of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line;
    end

    // Select the active transition.
    always_comb trig = edge_fall ? (line_q & ~line) : (line & ~line_q);

    // Pending latch: set on the active transition, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend <= 1'b0;
        else if (trig)     pend <= 1'b1;
        else if (pend_clr) pend <= 1'b0;
    end
endmodule

// File: rtl/tmr_irq_channel.sv
// Module: top of the shared-source timer interrupt channel. Holds the control and
// channel registers and the read mux, and ties flags, routing and the edge channel together.
// Assumes: single-cycle register accesses; read data is combinational from acc_addr.
module tmr_irq_channel
    import tmr_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_cap,
    input  logic          evt_cmp,
    input  logic          evt_ovf,
    input  logic [DW-1:0] cap_lo,
    input  logic [DW-1:0] cmp_lo,
    input  logic [DW-1:0] cnt_lo,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    output logic          irq_req,
    output logic [PW-1:0] irq_prio
);
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] src_en;
    logic            route;
    logic            edge_fall;
    logic            mask;
    logic [PW-1:0]   prio;
    logic            pend;
    logic            irq_line;
    logic            chan_wr;
    logic            ctrl_wr;
    logic            pend_clr;

    tmr_irq_flags #(
        .NSRC(NSRC), .AW(AW), .STAT_ADDR(A_STAT), .LO_BASE(LO_BASE)
    ) u_flags (
        .clk(clk), .rst_n(rst_n),
        .evt({evt_ovf, evt_cmp, evt_cap}),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .flags(flags)
    );

    // Decode register writes.
    always_comb begin
        ctrl_wr  = acc_en && acc_wr && (acc_addr == A_CTRL);
        chan_wr  = acc_en && acc_wr && (acc_addr == A_CHAN);
        pend_clr = chan_wr && !acc_wdata[1];
    end

    // Control register: source enables and routing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en <= '0;
            route  <= 1'b0;
        end else if (ctrl_wr) begin
            src_en <= acc_wdata[NSRC-1:0];
            route  <= acc_wdata[NSRC];
        end
    end

    // Channel register: edge select, mask and priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_fall <= 1'b0;
            mask      <= 1'b0;
            prio      <= '0;
        end else if (chan_wr) begin
            edge_fall <= acc_wdata[0];
            mask      <= acc_wdata[2];
            prio      <= acc_wdata[3 +: PW];
        end
    end

    // Shared line: enabled flags ORed, then gated by routing.
    always_comb irq_line = route & (|(flags & src_en));

    tmr_irq_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .line(irq_line), .edge_fall(edge_fall),
        .pend_clr(pend_clr), .pend(pend)
    );

    // Request outputs.
    always_comb begin
        irq_req  = pend & mask;
        irq_prio = prio;
    end

    // Read mux.
    always_comb begin
        acc_rdata = '0;
        case (acc_addr)
            A_STAT:   acc_rdata = DW'(flags);
            A_CTRL:   acc_rdata = DW'({route, src_en});
            A_CHAN:   acc_rdata = DW'({prio, mask, pend, edge_fall});
            A_CAP_LO: acc_rdata = cap_lo;
            A_CMP_LO: acc_rdata = cmp_lo;
            A_CNT_LO: acc_rdata = cnt_lo;
            default:  acc_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_irq_channel_chk.sv
// Module: assertion checker bound to tmr_irq_channel.
// Assumes: internal names flags, irq_line, edge_fall, pend, chan_wr in the top.
module tmr_irq_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_cap,
    input logic       evt_ovf,
    input logic       acc_en,
    input logic       acc_wr,
    input logic [2:0] acc_addr,
    input logic [2:0] flags,
    input logic       line,
    input logic       edge_fall,
    input logic       pend,
    input logic       chan_wr
);
    a_r2_cap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cap |=> flags[0]);

    a_r10_ovf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf |=> flags[2]);

    a_r3_rise_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_fall && $rose(line)) |=> pend);

    a_r7_no_edge_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && $stable(line)) |=> !pend);

    a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !chan_wr) |=> pend);

    a_r5_cap_clear_by_low_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(acc_en && !acc_wr && acc_addr == 3'd3));
endmodule

bind tmr_irq_channel tmr_irq_channel_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .evt_cap(evt_cap), .evt_ovf(evt_ovf),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .flags(flags), .line(irq_line), .edge_fall(edge_fall),
    .pend(pend), .chan_wr(chan_wr)
);

// File: tb/tmr_irq_channel_bench.sv
// Bench: directed scenarios, one task each, for the timer interrupt channel.
module tmr_irq_channel_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_cap = 1'b0, evt_cmp = 1'b0, evt_ovf = 1'b0;
    logic [7:0] cap_lo = 8'h11, cmp_lo = 8'h22, cnt_lo = 8'h33;
    logic       acc_en = 1'b0, acc_wr = 1'b0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       irq_req;
    logic [2:0] irq_prio;
    int checks = 0;
    int errors = 0;

    tmr_irq_channel u_tmr_irq_channel (
        .clk(clk), .rst_n(rst_n),
        .evt_cap(evt_cap), .evt_cmp(evt_cmp), .evt_ovf(evt_ovf),
        .cap_lo(cap_lo), .cmp_lo(cmp_lo), .cnt_lo(cnt_lo),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_req(irq_req), .irq_prio(irq_prio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One bus cycle, optionally with event pulses in the same cycle.
    task automatic op(input logic wr, input logic [2:0] a, input logic [7:0] wd,
                      input logic [2:0] ev, output logic [7:0] rd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = wd;
        {evt_ovf, evt_cmp, evt_cap} = ev;
        #1 rd = acc_rdata;
        @(posedge clk); #1;
        acc_en = 1'b0; acc_wr = 1'b0;
        {evt_ovf, evt_cmp, evt_cap} = 3'b000;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] unused;
        op(1'b1, a, d, 3'b000, unused);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        op(1'b0, a, 8'h00, 3'b000, d);
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk);
        {evt_ovf, evt_cmp, evt_cap} = ev;
        @(posedge clk); #1;
        {evt_ovf, evt_cmp, evt_cap} = 3'b000;
    endtask

    task automatic clear_flag(input logic [2:0] lo_addr);
        logic [7:0] d;
        rd(3'd0, d);
        rd(lo_addr, d);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 irq_req", {7'b0, irq_req}, 8'h00);
        check("R1 irq_prio", {5'b0, irq_prio}, 8'h00);
        rd(3'd0, d); check("R1 status", d, 8'h00);
        rd(3'd1, d); check("R1 control", d, 8'h00);
        rd(3'd2, d); check("R1 channel", d, 8'h00);
    endtask

    task automatic t_flag_gating;
        logic [7:0] d;
        pulse(3'b001); tick(1);
        rd(3'd0, d); check("R2 cap flag bit0", d, 8'h01);
        wr(3'd1, 8'h07);                      // enables on, routing off
        pulse(3'b010); tick(2);
        rd(3'd2, d); check("R4 routing off no pend", d & 8'h02, 8'h00);
        rd(3'd3, d); check("R5 low read returns data", d, 8'h11);
        rd(3'd0, d); check("R5 low read alone keeps flag", d, 8'h03);
        clear_flag(3'd3);
        rd(3'd0, d); check("R5 cap cleared", d, 8'h02);
        clear_flag(3'd4);
        rd(3'd0, d); check("R5 cmp cleared", d, 8'h00);
        wr(3'd1, 8'h0E);                      // route on, cap disabled
        pulse(3'b001); tick(2);
        rd(3'd2, d); check("R4 disabled source no pend", d & 8'h02, 8'h00);
        clear_flag(3'd3);
    endtask

    task automatic t_rise_and_mask;
        logic [7:0] d;
        wr(3'd1, 8'h0F);
        wr(3'd2, 8'h2C);                      // mask on, prio 5, rising
        check("R11 prio", {5'b0, irq_prio}, 8'h05);
        pulse(3'b010); tick(1);
        check("R3 irq after rise", {7'b0, irq_req}, 8'h01);
        wr(3'd2, 8'h2E);
        check("R8 write one keeps pend", {7'b0, irq_req}, 8'h01);
        wr(3'd2, 8'h28);                      // mask off, pend kept at 0? write 0 clears
        check("R11 mask off", {7'b0, irq_req}, 8'h00);
        wr(3'd2, 8'h2C);
        check("R8 pend cleared by zero", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_stall;
        logic [7:0] d;
        pulse(3'b100); tick(2);
        check("R7 stall while cmp set", {7'b0, irq_req}, 8'h00);
        clear_flag(3'd4);
        rd(3'd0, d); check("R7 only ovf left", d, 8'h04);
        clear_flag(3'd5);
        rd(3'd0, d); check("R7 all clear", d, 8'h00);
        pulse(3'b001); tick(1);
        check("R7 new edge after all clear", {7'b0, irq_req}, 8'h01);
        wr(3'd2, 8'h2C);
        clear_flag(3'd3);
    endtask

    task automatic t_cancel_and_collide;
        logic [7:0] d;
        pulse(3'b100); tick(1);
        wr(3'd2, 8'h2C);
        rd(3'd0, d); rd(3'd1, d); rd(3'd5, d);
        rd(3'd0, d); check("R6 intervening access cancels", d, 8'h04);
        rd(3'd5, d);
        rd(3'd0, d); check("R6 clean pair clears", d, 8'h00);
        pulse(3'b001); tick(1);
        wr(3'd2, 8'h2C);
        rd(3'd0, d);
        op(1'b0, 3'd3, 8'h00, 3'b001, d);
        rd(3'd0, d); check("R10 set wins over clear", d, 8'h01);
        clear_flag(3'd3);
        rd(3'd0, d); check("R10 later clear works", d, 8'h00);
        check("R3 fall ignored in rising mode", {7'b0, irq_req}, 8'h00);
    endtask

    task automatic t_falling;
        logic [7:0] d;
        wr(3'd2, 8'h2D);                      // falling, mask, prio 5
        pulse(3'b100); tick(2);
        check("R9 rise ignored", {7'b0, irq_req}, 8'h00);
        clear_flag(3'd5);
        tick(1);
        check("R9 irq on fall", {7'b0, irq_req}, 8'h01);
        wr(3'd2, 8'h2B);                      // keep pend, mask off
        check("R11 mask gates pend", {7'b0, irq_req}, 8'h00);
        rd(3'd2, d); check("R11 pend still set", d & 8'h02, 8'h02);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk) rst_n = 1'b1;
        tick(1);
        t_reset();
        t_flag_gating();
        t_rise_and_mask();
        t_stall();
        t_cancel_and_collide();
        t_falling();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule